// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Write-Back Data Cache

This block is a direct-mapped data cache that serves one CPU load/store at a time. The set is chosen from the untranslated page-offset bits of the access, so the line can be read while an external translation unit works out the physical page. One cycle after a request is accepted, the translation result (a page number and a hit flag) is presented. The stored tag of the selected line is compared with that physical page number, not with any bits of the virtual address. The page size is one full cache way (sets times line bytes), so the page offset is exactly the set index plus the byte offset.

If the translation hits but the tag does not match, the cache fetches the line from memory over a line-wide port. If the line it replaces holds modified data, that line is first written back. Stores update only the cache. Memory sees modified data only when such a line is evicted. A failed translation ends the access at once with a miss flag and touches neither the memory port nor the line storage.

The CPU raises a request and holds its inputs and the translation result until a one-cycle completion pulse. The busy output covers the whole access.

Top module: `vipt_cache`

## Requirements
- R1: The set index is word-offset bits [5:2] of `cpu_vword` (virtual address bits [7:4]), and the word within the line is bits [1:0]. A hit needs a valid line whose stored page number equals `tlb_ppn` while `tlb_hit` is 1. A load hit returns that word with `cpu_done` high exactly 2 cycles after the cycle in which the request was accepted, and issues no memory request.
- R2: On a translation hit with a tag miss, the line is read from memory at line address {`tlb_ppn`, set index}. The requested word of the fetched line is then returned.
- R3: If the replaced line is invalid or clean, the refill read is the only memory transaction of the access.
- R4: If the replaced line is valid and modified, the cache first writes its 4 words to line address {stored page number, set index}. Only after that write is acknowledged does it issue the refill read.
- R5: A store hit writes byte lane b of `cpu_wdata` (bits 8b+7:8b) into the addressed word only where `cpu_be[b]` is 1, and marks the line modified. Memory is not written until the line is replaced.
- R6: A store miss refills the line, merges the store bytes into it before completion, and leaves it modified.
- R7: When `tlb_hit` is 0, the access completes with `cpu_tlb_miss`=1. It makes no memory request and does not change any line.
- R8: After reset, `cpu_busy`, `cpu_done` and `mem_req` are 0 and every line is invalid.
- R9: `cpu_busy` is 1 from the cycle after acceptance through the completion cycle, and `cpu_done` lasts one cycle. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`.
- R10: The same virtual address translated to a different physical page misses, even though the set holds a valid line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_vword | input | 6 | Word address within the virtual page |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_tlb_miss | output | 1 | Completion was a translation miss |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| tlb_hit | input | 1 | Translation valid (sampled one cycle after acceptance) |
| tlb_ppn | input | 12 | Translated physical page number |
| mem_req | output | 1 | Memory line transaction request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 16 | Physical line address {page, set} |
| mem_wline | output | 128 | Write-back line data |
| mem_rline | input | 128 | Refill line data, valid with `mem_ack` |
| mem_ack | input | 1 | Transaction acknowledge |

## Verification
Several properties are checked on every cycle by assertions. The completion pulse is a single cycle, and memory request fields stay stable while waiting for acknowledge. An acknowledged write-back is always followed by a refill read. A failed translation goes straight to completion with the miss flag and no memory request. Only the bench's reference model can show that the data is correct end to end. It tracks which physical line each set holds and its modified state, and it predicts the exact memory transactions and loaded words. This covers byte merging, modified data coming back after eviction, conflict and remapped-page misses, and the unchanged line after a translation miss.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOKUP = 3'd1,
    ST_WBACK  = 3'd2,
    ST_REFILL = 3'd3,
    ST_RESP   = 3'd4
  } st_e;
endpackage

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic xlat_ok,
  input  logic tag_hit,
  input  logic victim_dirty,
  input  logic mem_ack,
  output st_e  state
);
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (req) st_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (!xlat_ok || tag_hit) st_d = ST_RESP;
        else if (victim_dirty)   st_d = ST_WBACK;
        else                     st_d = ST_REFILL;
      end
      ST_WBACK:  if (mem_ack) st_d = ST_REFILL;
      ST_REFILL: if (mem_ack) st_d = ST_RESP;
      ST_RESP:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/vipt_array.sv
module vipt_array #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 12,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_v;
  logic [SETS-1:0]   dirty_v;
  logic [TAG_W-1:0]  tag_a  [SETS];
  logic [LINE_W-1:0] line_a [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic              v_q, d_q;
    logic [TAG_W-1:0]  t_q;
    logic [LINE_W-1:0] l_q;
    logic              sel_en;

    assign sel_en = wr_en && (rd_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (sel_en) begin
        v_q <= 1'b1;
        d_q <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_en) begin
        t_q <= wr_tag;
        l_q <= wr_line;
      end
    end

    assign valid_v[s] = v_q;
    assign dirty_v[s] = d_q;
    assign tag_a[s]   = t_q;
    assign line_a[s]  = l_q;
  end

  assign rd_valid = valid_v[rd_idx];
  assign rd_dirty = dirty_v[rd_idx];
  assign rd_tag   = tag_a[rd_idx];
  assign rd_line  = line_a[rd_idx];
endmodule

// File: rtl/vipt_merge.sv
module vipt_merge #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W  = $clog2(WORDS),
  localparam int BE_W   = DATA_W / 8,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              en,
  input  logic [SEL_W-1:0]  word_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  input  logic [LINE_W-1:0] line_in,
  output logic [LINE_W-1:0] line_out
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
      assign line_out[w*DATA_W + b*8 +: 8] =
        (en && word_sel == SEL_W'(w) && be[b]) ? wdata[b*8 +: 8]
                                               : line_in[w*DATA_W + b*8 +: 8];
    end
  end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int PPN_W  = 12,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W  = $clog2(WORDS),
  localparam int BE_W   = DATA_W / 8,
  localparam int LINE_W = WORDS * DATA_W,
  localparam int VW_W   = IDX_W + SEL_W,
  localparam int MA_W   = PPN_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [VW_W-1:0]   cpu_vword,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [BE_W-1:0]   cpu_be,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic              cpu_tlb_miss,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  input  logic [LINE_W-1:0] mem_rline,
  input  logic              mem_ack
);
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  st_e st;

  logic [VW_W-1:0]   vw_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic [BE_W-1:0]   be_q;
  logic [PPN_W-1:0]  ppn_q;
  logic              miss_q;
  logic [DATA_W-1:0] rdata_q;

  logic [IDX_W-1:0]  idx;
  logic [SEL_W-1:0]  wsel;
  logic              rd_valid, rd_dirty, tag_hit;
  logic [PPN_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line, merge_src, merged, wr_line;
  logic              wr_en, wr_dirty;
  logic [PPN_W-1:0]  wr_tag;
  logic              en_req, en_look, en_rdata;

  assign idx  = vw_q[VW_W-1:SEL_W];
  assign wsel = vw_q[SEL_W-1:0];

  assign tag_hit = rd_valid && (rd_tag == tlb_ppn);

  vipt_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req          (cpu_req),
    .xlat_ok      (tlb_hit),
    .tag_hit      (tag_hit),
    .victim_dirty (rd_valid && rd_dirty),
    .mem_ack      (mem_ack),
    .state        (st)
  );

  assign en_req   = (st == ST_IDLE) && cpu_req;
  assign en_look  = (st == ST_LOOKUP);
  assign en_rdata = (en_look && tlb_hit && tag_hit) || (st == ST_REFILL && mem_ack);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vw_q    <= '0;
      we_q    <= 1'b0;
      wd_q    <= '0;
      be_q    <= '0;
      ppn_q   <= '0;
      miss_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (en_req) begin
        vw_q <= cpu_vword;
        we_q <= cpu_we;
        wd_q <= cpu_wdata;
        be_q <= cpu_be;
      end
      if (en_look) begin
        ppn_q  <= tlb_ppn;
        miss_q <= !tlb_hit;
      end
      if (en_rdata) rdata_q <= merged[wsel*DATA_W +: DATA_W];
    end
  end

  assign merge_src = (st == ST_REFILL) ? mem_rline : rd_line;

  vipt_merge #(.WORDS(WORDS), .DATA_W(DATA_W)) u_merge (
    .en       (we_q),
    .word_sel (wsel),
    .wdata    (wd_q),
    .be       (be_q),
    .line_in  (merge_src),
    .line_out (merged)
  );

  assign wr_en    = (en_look && tlb_hit && tag_hit && we_q) || (st == ST_REFILL && mem_ack);
  assign wr_dirty = en_look ? 1'b1 : we_q;
  assign wr_tag   = (st == ST_REFILL) ? ppn_q : rd_tag;
  assign wr_line  = merged;

  vipt_array #(.IDX_W(IDX_W), .TAG_W(PPN_W), .LINE_W(LINE_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_idx   (idx),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_tag   (rd_tag),
    .rd_line  (rd_line),
    .wr_en    (wr_en),
    .wr_dirty (wr_dirty),
    .wr_tag   (wr_tag),
    .wr_line  (wr_line)
  );

  assign mem_req   = (st == ST_WBACK) || (st == ST_REFILL);
  assign mem_we    = (st == ST_WBACK);
  assign mem_addr  = (st == ST_WBACK) ? {rd_tag, idx} : {ppn_q, idx};
  assign mem_wline = rd_line;

  assign cpu_busy     = (st != ST_IDLE);
  assign cpu_done     = (st == ST_RESP);
  assign cpu_tlb_miss = cpu_done && miss_q;
  assign cpu_rdata    = rdata_q;
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk
  import vipt_pkg::*;
#(
  parameter int MA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input st_e             state,
  input logic            tlb_hit,
  input logic            cpu_done,
  input logic            cpu_tlb_miss,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [MA_W-1:0] mem_addr
);
  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  // R9: a pending memory request keeps its fields until acknowledged
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4: an acknowledged write-back is followed by the refill read
  p_wb_then_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  // R7: failed translation completes next cycle without memory traffic
  p_tlbmiss_nomem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOKUP && !tlb_hit) |=> (cpu_done && !mem_req));

  // R7: the miss flag accompanies that completion
  p_tlbmiss_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOKUP && !tlb_hit) |=> cpu_tlb_miss);
endmodule

bind vipt_cache vipt_cache_chk #(.MA_W(MA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .state        (st),
  .tlb_hit      (tlb_hit),
  .cpu_done     (cpu_done),
  .cpu_tlb_miss (cpu_tlb_miss),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr)
);

// File: tb/tb_vipt_cache.sv
module tb_vipt_cache;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         cpu_req, cpu_we;
  logic [5:0]   cpu_vword;
  logic [31:0]  cpu_wdata;
  logic [3:0]   cpu_be;
  logic         cpu_busy, cpu_done, cpu_tlb_miss;
  logic [31:0]  cpu_rdata;
  logic         tlb_hit;
  logic [11:0]  tlb_ppn;
  logic         mem_req, mem_we;
  logic [15:0]  mem_addr;
  logic [127:0] mem_wline, mem_rline;
  logic         mem_ack;

  vipt_cache dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_vword(cpu_vword), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_tlb_miss(cpu_tlb_miss),
    .cpu_rdata(cpu_rdata), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // translation table of the bench
  logic [11:0] tmap [256];
  bit          tok  [256];

  function automatic logic [127:0] init_line(int a);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = 32'hC0DE0000 ^ (a << 8) ^ w;
    return r;
  endfunction

  logic [127:0] ref_mem [int];
  logic [127:0] mem_img [int];

  function automatic logic [127:0] ref_get(int a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return init_line(a);
  endfunction

  // reference cache state
  bit m_v [16];
  bit m_d [16];
  int m_t [16];

  bit           q_we   [$];
  int           q_addr [$];
  logic [127:0] q_line [$];

  int lat = 2;

  // memory responder and transaction monitor
  initial begin
    int cnt;
    int a;
    bit ew;
    int ea;
    logic [127:0] el;
    cnt = 0;
    mem_ack = 1'b0;
    mem_rline = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        cnt++;
        if (cnt >= lat) begin
          cnt = 0;
          a = int'(mem_addr);
          if (q_we.size() == 0) begin
            chk(0, "R7", "unexpected memory transaction", mem_addr, 0);
          end else begin
            ew = q_we.pop_front();
            ea = q_addr.pop_front();
            el = q_line.pop_front();
            chk(mem_we == ew, ew ? "R4" : "R3", "memory op kind", mem_we, ew);
            chk(a == ea, ew ? "R4" : "R2", "memory line address", a, ea);
            if (ew) chk(mem_wline == el, "R5", "write-back line data", mem_wline, el);
          end
          if (mem_we) mem_img[a] = mem_wline;
          else mem_rline = mem_img.exists(a) ? mem_img[a] : init_line(a);
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic access(bit we, logic [15:0] va, logic [31:0] wd, logic [3:0] be, string rq);
    int vpn, idx, sel, pa, cyc;
    bit exp_miss, exp_hit, busy_seen;
    logic [127:0] ln;
    logic [31:0] exp_rd;
    vpn = int'(va[15:8]);
    idx = int'(va[7:4]);
    sel = int'(va[3:2]);
    exp_miss = !tok[vpn];
    exp_hit = 1'b0;
    exp_rd = '0;
    if (!exp_miss) begin
      pa = (int'(tmap[vpn]) << 4) | idx;
      if (m_v[idx] && m_t[idx] == int'(tmap[vpn])) exp_hit = 1'b1;
      else begin
        if (m_v[idx] && m_d[idx]) begin
          q_we.push_back(1'b1);
          q_addr.push_back((m_t[idx] << 4) | idx);
          q_line.push_back(ref_get((m_t[idx] << 4) | idx));
        end
        q_we.push_back(1'b0);
        q_addr.push_back(pa);
        q_line.push_back('0);
        m_v[idx] = 1'b1;
        m_t[idx] = int'(tmap[vpn]);
        m_d[idx] = 1'b0;
      end
      ln = ref_get(pa);
      if (we) begin
        for (int b = 0; b < 4; b++)
          if (be[b]) ln[sel*32 + b*8 +: 8] = wd[b*8 +: 8];
        ref_mem[pa] = ln;
        m_d[idx] = 1'b1;
      end
      exp_rd = ln[sel*32 +: 32];
    end
    @(negedge clk);
    cpu_req = 1'b1;
    cpu_we = we;
    cpu_vword = va[7:2];
    cpu_wdata = wd;
    cpu_be = be;
    tlb_hit = tok[vpn];
    tlb_ppn = tmap[vpn];
    cyc = 0;
    busy_seen = 1'b0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) busy_seen = cpu_busy;
    end while (!cpu_done && cyc < 200);
    chk(cpu_done == 1'b1, "R9", {rq, " completion seen"}, cpu_done, 1);
    chk(busy_seen == 1'b1, "R9", {rq, " busy after accept"}, busy_seen, 1);
    chk(cpu_tlb_miss == exp_miss, exp_miss ? "R7" : rq, "translation miss flag", cpu_tlb_miss, exp_miss);
    if (!exp_miss) chk(cpu_rdata == exp_rd, rq, "returned word", cpu_rdata, exp_rd);
    if (exp_hit) chk(cyc == 2, "R1", "hit latency", cyc, 2);
    chk(q_we.size() == 0, rq, "pending expected memory transactions", q_we.size(), 0);
    cpu_req = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] saved;
    logic [15:0] lf;
    for (int v = 0; v < 256; v++) begin
      tmap[v] = 12'(v * 7 + 3);
      tok[v]  = (v % 16) != 15;
    end
    for (int s = 0; s < 16; s++) begin
      m_v[s] = 1'b0; m_d[s] = 1'b0; m_t[s] = 0;
    end
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_vword = '0; cpu_wdata = '0; cpu_be = '0;
    tlb_hit = 1'b0; tlb_ppn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cpu_busy == 1'b0, "R8", "busy after reset", cpu_busy, 0);
    chk(cpu_done == 1'b0, "R8", "done after reset", cpu_done, 0);
    chk(mem_req == 1'b0, "R8", "mem_req after reset", mem_req, 0);

    access(0, 16'h0010, 0, 0, "R2");              // cold miss, clean refill (R3)
    access(0, 16'h0018, 0, 0, "R1");              // load hit, other word
    access(1, 16'h0014, 32'hA1B2C3D4, 4'b0101, "R5");
    access(0, 16'h0014, 0, 0, "R5");              // merged bytes visible
    access(0, 16'h0110, 0, 0, "R4");              // conflict, dirty victim
    access(0, 16'h0014, 0, 0, "R3");              // clean victim, data from memory
    access(1, 16'h0234, 32'h5566_7788, 4'b1111, "R6");
    access(0, 16'h0234, 0, 0, "R6");
    access(0, 16'h0F30, 0, 0, "R7");              // translation miss, load
    access(1, 16'h0F34, 32'hDEAD_BEEF, 4'b1111, "R7");
    access(0, 16'h0234, 0, 0, "R7");              // set 3 unchanged: hits
    saved = tmap[2];
    tmap[2] = 12'hF00;
    access(0, 16'h0234, 0, 0, "R10");             // same VA, new page: miss
    tmap[2] = saved;
    access(1, 16'h0230, 32'h0BAD_F00D, 4'b0011, "R10");

    lf = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lat = 1 + (i % 3);
      access(lf[0], {4'h0, 4'((lf[15:13] == 3'd7) ? 15 : int'(lf[11:10])), lf[7:4], lf[3:2], 2'b00},
             {lf, ~lf}, lf[9:6], "R1");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule